// File: doc/BRIEF.md
# MSI L1 Line Coherence Controller

This block tracks the coherence state of one line of a private first-level cache. The cache sits under an inclusive, shared second-level directory and uses an MSI protocol. Each cycle the block takes at most one event from three sources:

- a processor queue, carrying load, instruction fetch, store, replacement and wrong-side writeback;
- a forwarded-request queue from the directory, carrying invalidate-modified, invalidate-shared and forced downgrade;
- a fill/acknowledge queue from the directory, carrying plain data, data-then-shared, data-then-idle and put-acknowledge.

From that event it decides the next state. It emits, as needed:

- a request to the directory (GETS, instruction GET, GETX, UPGRADE, PUTS, PUTX);
- a response to the directory (data or invalidation acknowledge);
- completion strobes toward the processor;
- pop strobes for the queue it served.

A small datapath holds the line word, a transaction buffer and a pending-store word. The transaction buffer keeps the victim copy after an eviction, so that a forwarded request that races with the eviction can still be answered with data. The pending-store word holds the store value until the exclusive fill arrives. Eight transient states absorb invalidations and downgrades that arrive while a fill is still outstanding. At most one transaction is in flight at a time.

All outputs are registered. An event sampled at a rising edge shows its strobes, messages and new state just after that edge.

Top module: `msi_l1_line_ctl`

## Requirements

- R1: After synchronous reset, `line_state` is 0 (not present), `line_perm` is 0, `proto_err` is 0, and every strobe and valid output is 0. State codes are: NP=0, I=1, S=2, M=3, IS=4, ISI=5, IM=6, IMI=7, IMS=8, IMSI=9, SI=10, MI=11.
- R2: Per cycle, only one event is served. A fill/ack (`fill_valid`) wins over a forwarded request (`fwd_valid`), which wins over a processor event. Exactly the served queue's pop strobe rises. A processor event that is not consumed raises `cpu_stall` and leaves `cpu_pop` low.
- R3: In any transient state (codes 4 to 11), every processor event stalls: it is not popped and the state does not change.
- R4: In NP or I, processor ops act as follows (op codes load=0, ifetch=1, store=2, replace=3, writeback=4):
  - load sends GETS (request type 0) and enters IS;
  - ifetch sends the instruction GET (type 1) and enters IS;
  - store sends GETX (type 2), latches `cpu_wdata` and enters IM;
  - replace or writeback frees the line (NP) with no message.
- R5: In S, processor and forwarded events act as follows:
  - load or ifetch pulses `load_done` with the line word;
  - store sends UPGRADE (type 3), latches the store word and enters IM;
  - replace or writeback sends PUTS (type 4) carrying the line, copies the line into the transaction buffer and enters SI;
  - invalidate-shared (forwarded op 1) answers with an invalidation ack (response type 1) and enters I.
- R6: In M, processor and forwarded events act as follows:
  - load or ifetch completes from the line;
  - store overwrites the line and pulses `store_done`;
  - invalidate-modified (forwarded op 0) sends data (response type 0) and enters I;
  - downgrade (forwarded op 2) sends data and enters S;
  - replace sends PUTX (type 5) with the line, buffers it and enters MI.
- R7: In IS, an invalidate-shared is acked and moves the line to ISI. Fill ops are data=0, data-then-shared=1, data-then-idle=2, put-ack=3.
  - In IS, data completes the load with the fill word and enters S.
  - In IS, data-then-idle completes the load and enters I.
  - In ISI, data completes the load and enters I.
- R8: In IM, a forwarded request that races with the fill is handled as follows:
  - invalidate-modified moves to IMI with no response;
  - downgrade moves to IMS with no response;
  - invalidate-shared is acked and the line stays in IM.
  - In IMS, invalidate-shared moves to IMSI.
- R9: In IM, a fill completes the store: the line takes the store word and `store_done` pulses. Then:
  - plain data ends in M;
  - data-then-shared sends the store word to the directory and ends in S;
  - data-then-idle sends the store word to the directory and ends in I.
- R10: In IMI, IMS and IMSI, data completes the store and sends the store word as a data response. The line ends in I, S and I respectively.
- R11: In MI, invalidate-modified is answered with data from the transaction buffer. In MI, downgrade is answered the same way and moves to SI. In SI, invalidate-shared is acked. A put-ack in SI or MI moves to I.
- R12: `line_perm` follows the state. NP, I, SI and MI give 0 (invalid). S gives 1 (read-only). M gives 2 (read-write). All other states give 3 (busy).
- R13: An event that is illegal in the current state, or that carries an unused op code, is popped but changes no state and sends nothing. It sets `proto_err`, which stays set until reset.
- R14: Every output reflects the event sampled at the previous rising edge, one register stage after the inputs.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_valid | input | 1 | Processor event present |
| cpu_op | input | 3 | Processor op code |
| cpu_wdata | input | DATA_W | Store word |
| fwd_valid | input | 1 | Forwarded request present |
| fwd_op | input | 2 | Forwarded op code |
| fill_valid | input | 1 | Fill or ack present |
| fill_op | input | 2 | Fill op code |
| fill_data | input | DATA_W | Fill word |
| cpu_pop | output | 1 | Processor event consumed |
| fwd_pop | output | 1 | Forwarded request consumed |
| fill_pop | output | 1 | Fill or ack consumed |
| cpu_stall | output | 1 | Processor event held back |
| load_done | output | 1 | Load or ifetch completed |
| load_data | output | DATA_W | Word returned with load_done |
| store_done | output | 1 | Store completed |
| req_valid | output | 1 | Request to directory |
| req_type | output | 3 | Request code |
| req_data | output | DATA_W | Line carried by PUTS/PUTX |
| resp_valid | output | 1 | Response to directory |
| resp_type | output | 1 | 0 data, 1 invalidation ack |
| resp_data | output | DATA_W | Word carried by a data response |
| line_state | output | 4 | Current state code |
| line_perm | output | 2 | Access permission |
| proto_err | output | 1 | Sticky protocol error |

## Verification

The collisions of interest are a fill arriving together with a forwarded request, and a forwarded request arriving together with a processor event. In both cases only the higher-priority source may act. Directed steps raise two or three valids in the same cycle, for example a store with an invalidate-shared while in S, and a fill with a downgrade while in IM. A reference model then judges which pop rose, whether the processor event stalled, and whether the state and messages came only from the winner. Seeded random traffic biased toward transient states produces further coincidences, each scored by the same model.

// File: rtl/msi_l1_pkg.sv
package msi_l1_pkg;

  typedef enum logic [3:0] {
    ST_NP = 4'd0, ST_I = 4'd1, ST_S = 4'd2, ST_M = 4'd3,
    ST_IS = 4'd4, ST_ISI = 4'd5, ST_IM = 4'd6, ST_IMI = 4'd7,
    ST_IMS = 4'd8, ST_IMSI = 4'd9, ST_SI = 4'd10, ST_MI = 4'd11
  } lstate_e;

  // processor op codes
  localparam logic [2:0] OP_LOAD = 3'd0;
  localparam logic [2:0] OP_IFETCH = 3'd1;
  localparam logic [2:0] OP_STORE = 3'd2;
  localparam logic [2:0] OP_REPL = 3'd3;
  localparam logic [2:0] OP_WBACK = 3'd4;

  // forwarded op codes
  localparam logic [1:0] FW_INV_M = 2'd0;
  localparam logic [1:0] FW_INV_S = 2'd1;
  localparam logic [1:0] FW_DOWNGRADE = 2'd2;

  // fill op codes
  localparam logic [1:0] FL_DATA = 2'd0;
  localparam logic [1:0] FL_DATA_S = 2'd1;
  localparam logic [1:0] FL_DATA_I = 2'd2;
  localparam logic [1:0] FL_PUTACK = 2'd3;

  // outgoing request and response codes
  localparam logic [2:0] REQ_GETS = 3'd0;
  localparam logic [2:0] REQ_GETI = 3'd1;
  localparam logic [2:0] REQ_GETX = 3'd2;
  localparam logic [2:0] REQ_UPGRADE = 3'd3;
  localparam logic [2:0] REQ_PUTS = 3'd4;
  localparam logic [2:0] REQ_PUTX = 3'd5;
  localparam logic RSP_DATA = 1'b0;
  localparam logic RSP_ACK = 1'b1;

  typedef enum logic [1:0] {SRC_NONE, SRC_FILL, SRC_FWD, SRC_CPU} src_e;
  typedef enum logic [2:0] {D_NONE, D_LINE, D_TBUF, D_PEND, D_FILL} dsrc_e;
  typedef enum logic [1:0] {W_NONE, W_FILL, W_PEND, W_CPU} lwr_e;

  typedef struct packed {
    lstate_e    nxt;
    logic       cpu_take;
    logic       err;
    logic       req_v;
    logic [2:0] req_t;
    dsrc_e      req_src;
    logic       rsp_v;
    logic       rsp_t;
    dsrc_e      rsp_src;
    logic       ld_done;
    dsrc_e      rd_src;
    logic       st_done;
    lwr_e       line_wr;
    logic       tb_ld;
    logic       pend_ld;
  } act_t;

  function automatic logic is_transient(lstate_e s);
    return s >= ST_IS;
  endfunction

  function automatic logic [1:0] perm_of(lstate_e s);
    case (s)
      ST_NP, ST_I, ST_SI, ST_MI: return 2'd0;
      ST_S:                      return 2'd1;
      ST_M:                      return 2'd2;
      default:                   return 2'd3;
    endcase
  endfunction

endpackage

// File: rtl/msi_l1_arb.sv
module msi_l1_arb
  import msi_l1_pkg::*;
(
  input  logic cpu_v,
  input  logic fwd_v,
  input  logic fill_v,
  output src_e src
);
  // fills retire transactions, so they go first; forwarded requests next
  always_comb begin
    if (fill_v)      src = SRC_FILL;
    else if (fwd_v)  src = SRC_FWD;
    else if (cpu_v)  src = SRC_CPU;
    else             src = SRC_NONE;
  end
endmodule

// File: rtl/msi_l1_fsm.sv
module msi_l1_fsm
  import msi_l1_pkg::*;
(
  input  lstate_e    st,
  input  src_e       src,
  input  logic [2:0] cpu_op,
  input  logic [1:0] fwd_op,
  input  logic [1:0] fill_op,
  output act_t       act
);
  always_comb begin
    act = '0;
    act.nxt = st;
    case (src)
      SRC_CPU: begin
        if (!is_transient(st)) begin
          act.cpu_take = 1'b1;
          case (st)
            ST_NP, ST_I: begin
              case (cpu_op)
                OP_LOAD:   begin act.nxt = ST_IS; act.req_v = 1'b1; act.req_t = REQ_GETS; end
                OP_IFETCH: begin act.nxt = ST_IS; act.req_v = 1'b1; act.req_t = REQ_GETI; end
                OP_STORE:  begin act.nxt = ST_IM; act.req_v = 1'b1; act.req_t = REQ_GETX; act.pend_ld = 1'b1; end
                OP_REPL, OP_WBACK: act.nxt = ST_NP;
                default:   act.err = 1'b1;
              endcase
            end
            ST_S: begin
              case (cpu_op)
                OP_LOAD, OP_IFETCH: begin act.ld_done = 1'b1; act.rd_src = D_LINE; end
                OP_STORE: begin act.nxt = ST_IM; act.req_v = 1'b1; act.req_t = REQ_UPGRADE; act.pend_ld = 1'b1; end
                OP_REPL, OP_WBACK: begin
                  act.nxt = ST_SI; act.req_v = 1'b1; act.req_t = REQ_PUTS;
                  act.req_src = D_LINE; act.tb_ld = 1'b1;
                end
                default: act.err = 1'b1;
              endcase
            end
            default: begin // ST_M
              case (cpu_op)
                OP_LOAD, OP_IFETCH: begin act.ld_done = 1'b1; act.rd_src = D_LINE; end
                OP_STORE: begin act.st_done = 1'b1; act.line_wr = W_CPU; end
                OP_REPL, OP_WBACK: begin
                  act.nxt = ST_MI; act.req_v = 1'b1; act.req_t = REQ_PUTX;
                  act.req_src = D_LINE; act.tb_ld = 1'b1;
                end
                default: act.err = 1'b1;
              endcase
            end
          endcase
        end
      end
      SRC_FWD: begin
        case (st)
          ST_S: if (fwd_op == FW_INV_S) begin
                  act.nxt = ST_I; act.rsp_v = 1'b1; act.rsp_t = RSP_ACK;
                end else act.err = 1'b1;
          ST_M: if (fwd_op == FW_INV_M || fwd_op == FW_DOWNGRADE) begin
                  act.nxt = (fwd_op == FW_INV_M) ? ST_I : ST_S;
                  act.rsp_v = 1'b1; act.rsp_t = RSP_DATA; act.rsp_src = D_LINE;
                end else act.err = 1'b1;
          ST_IS: if (fwd_op == FW_INV_S) begin
                   act.nxt = ST_ISI; act.rsp_v = 1'b1; act.rsp_t = RSP_ACK;
                 end else act.err = 1'b1;
          ST_IM: begin
            case (fwd_op)
              FW_INV_M:     act.nxt = ST_IMI;
              FW_DOWNGRADE: act.nxt = ST_IMS;
              FW_INV_S:     begin act.rsp_v = 1'b1; act.rsp_t = RSP_ACK; end
              default:      act.err = 1'b1;
            endcase
          end
          ST_IMS: if (fwd_op == FW_INV_S) act.nxt = ST_IMSI;
                  else act.err = 1'b1;
          ST_SI: if (fwd_op == FW_INV_S) begin
                   act.rsp_v = 1'b1; act.rsp_t = RSP_ACK;
                 end else act.err = 1'b1;
          ST_MI: if (fwd_op == FW_INV_M || fwd_op == FW_DOWNGRADE) begin
                   act.nxt = (fwd_op == FW_INV_M) ? ST_MI : ST_SI;
                   act.rsp_v = 1'b1; act.rsp_t = RSP_DATA; act.rsp_src = D_TBUF;
                 end else act.err = 1'b1;
          default: act.err = 1'b1;
        endcase
      end
      SRC_FILL: begin
        case (st)
          ST_IS, ST_ISI: if (fill_op == FL_DATA || (st == ST_IS && fill_op == FL_DATA_I)) begin
                   act.nxt = (st == ST_IS && fill_op == FL_DATA) ? ST_S : ST_I;
                   act.line_wr = W_FILL; act.ld_done = 1'b1; act.rd_src = D_FILL;
                 end else act.err = 1'b1;
          ST_IM: begin
            if (fill_op == FL_PUTACK) act.err = 1'b1;
            else begin
              act.line_wr = W_PEND; act.st_done = 1'b1;
              case (fill_op)
                FL_DATA:   act.nxt = ST_M;
                FL_DATA_S: act.nxt = ST_S;
                default:   act.nxt = ST_I;
              endcase
              if (fill_op != FL_DATA) begin
                act.rsp_v = 1'b1; act.rsp_t = RSP_DATA; act.rsp_src = D_PEND;
              end
            end
          end
          ST_IMI, ST_IMS, ST_IMSI: if (fill_op == FL_DATA) begin
                   act.nxt = (st == ST_IMS) ? ST_S : ST_I;
                   act.line_wr = W_PEND; act.st_done = 1'b1;
                   act.rsp_v = 1'b1; act.rsp_t = RSP_DATA; act.rsp_src = D_PEND;
                 end else act.err = 1'b1;
          ST_SI, ST_MI: if (fill_op == FL_PUTACK) act.nxt = ST_I;
                        else act.err = 1'b1;
          default: act.err = 1'b1;
        endcase
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/msi_l1_line_ctl.sv
module msi_l1_line_ctl
  import msi_l1_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_valid,
  input  logic [2:0]        cpu_op,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              fwd_valid,
  input  logic [1:0]        fwd_op,
  input  logic              fill_valid,
  input  logic [1:0]        fill_op,
  input  logic [DATA_W-1:0] fill_data,
  output logic              cpu_pop,
  output logic              fwd_pop,
  output logic              fill_pop,
  output logic              cpu_stall,
  output logic              load_done,
  output logic [DATA_W-1:0] load_data,
  output logic              store_done,
  output logic              req_valid,
  output logic [2:0]        req_type,
  output logic [DATA_W-1:0] req_data,
  output logic              resp_valid,
  output logic              resp_type,
  output logic [DATA_W-1:0] resp_data,
  output logic [3:0]        line_state,
  output logic [1:0]        line_perm,
  output logic              proto_err
);
  lstate_e           st;
  src_e              src;
  act_t              act;
  logic [DATA_W-1:0] line_q, tbuf_q, pend_q;

  msi_l1_arb u_arb (
    .cpu_v (cpu_valid),
    .fwd_v (fwd_valid),
    .fill_v(fill_valid),
    .src   (src)
  );

  msi_l1_fsm u_fsm (
    .st     (st),
    .src    (src),
    .cpu_op (cpu_op),
    .fwd_op (fwd_op),
    .fill_op(fill_op),
    .act    (act)
  );

  function automatic logic [DATA_W-1:0] pick(dsrc_e s);
    case (s)
      D_LINE:  return line_q;
      D_TBUF:  return tbuf_q;
      D_PEND:  return pend_q;
      D_FILL:  return fill_data;
      default: return '0;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_NP;
      line_q     <= '0;
      tbuf_q     <= '0;
      pend_q     <= '0;
      proto_err  <= 1'b0;
      cpu_pop    <= 1'b0;
      fwd_pop    <= 1'b0;
      fill_pop   <= 1'b0;
      cpu_stall  <= 1'b0;
      load_done  <= 1'b0;
      load_data  <= '0;
      store_done <= 1'b0;
      req_valid  <= 1'b0;
      req_type   <= '0;
      req_data   <= '0;
      resp_valid <= 1'b0;
      resp_type  <= 1'b0;
      resp_data  <= '0;
    end else begin
      st <= act.nxt;
      case (act.line_wr)
        W_FILL:  line_q <= fill_data;
        W_PEND:  line_q <= pend_q;
        W_CPU:   line_q <= cpu_wdata;
        default: ;
      endcase
      if (act.tb_ld)   tbuf_q <= line_q;
      if (act.pend_ld) pend_q <= cpu_wdata;
      proto_err  <= proto_err | act.err;
      cpu_pop    <= act.cpu_take;
      fwd_pop    <= (src == SRC_FWD);
      fill_pop   <= (src == SRC_FILL);
      cpu_stall  <= cpu_valid & ~act.cpu_take;
      load_done  <= act.ld_done;
      load_data  <= pick(act.rd_src);
      store_done <= act.st_done;
      req_valid  <= act.req_v;
      req_type   <= act.req_t;
      req_data   <= pick(act.req_src);
      resp_valid <= act.rsp_v;
      resp_type  <= act.rsp_t;
      resp_data  <= pick(act.rsp_src);
    end
  end

  assign line_state = st;
  assign line_perm  = perm_of(st);

endmodule

// File: rtl/msi_l1_chk.sv
module msi_l1_chk
  import msi_l1_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       cpu_pop,
  input logic       fwd_pop,
  input logic       fill_pop,
  input logic       cpu_stall,
  input logic       load_done,
  input logic       store_done,
  input logic       req_valid,
  input logic [2:0] req_type,
  input logic [3:0] line_state,
  input logic [1:0] line_perm,
  input logic       proto_err
);
  assert_state_legal_R1: assert property (@(posedge clk) disable iff (rst)
    line_state <= 4'd11);

  assert_one_pop_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cpu_pop, fwd_pop, fill_pop}));

  assert_stall_no_pop_R3: assert property (@(posedge clk) disable iff (rst)
    cpu_stall |-> !cpu_pop);

  assert_putx_in_mi_R6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_type == REQ_PUTX) |-> line_state == ST_M + 4'd8);

  assert_done_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
    !(load_done && store_done));

  assert_load_end_state_R7: assert property (@(posedge clk) disable iff (rst)
    load_done |-> (line_state == ST_S || line_state == ST_M || line_state == ST_I));

  assert_rw_only_m_R12: assert property (@(posedge clk) disable iff (rst)
    line_perm == 2'd2 |-> line_state == ST_M);

  assert_err_sticky_R13: assert property (@(posedge clk) disable iff (rst)
    proto_err |=> proto_err);
endmodule

bind msi_l1_line_ctl msi_l1_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .cpu_pop   (cpu_pop),
  .fwd_pop   (fwd_pop),
  .fill_pop  (fill_pop),
  .cpu_stall (cpu_stall),
  .load_done (load_done),
  .store_done(store_done),
  .req_valid (req_valid),
  .req_type  (req_type),
  .line_state(line_state),
  .line_perm (line_perm),
  .proto_err (proto_err)
);

// File: tb/test_msi_l1_line_ctl.sv
`timescale 1ns/1ps
module test_msi_l1_line_ctl;
  localparam int W = 16;
  localparam int NP = 0, I = 1, S = 2, M = 3, IS = 4, ISI = 5, IM = 6, IMI = 7,
                 IMS = 8, IMSI = 9, SI = 10, MI = 11;

  logic clk = 1'b0, rst = 1'b1;
  logic cpu_valid = 0, fwd_valid = 0, fill_valid = 0;
  logic [2:0] cpu_op = 0;
  logic [1:0] fwd_op = 0, fill_op = 0;
  logic [W-1:0] cpu_wdata = 0, fill_data = 0;
  logic cpu_pop, fwd_pop, fill_pop, cpu_stall, load_done, store_done;
  logic req_valid, resp_valid, resp_type, proto_err;
  logic [2:0] req_type;
  logic [1:0] line_perm;
  logic [3:0] line_state;
  logic [W-1:0] load_data, req_data, resp_data;

  always #4 clk = ~clk;

  msi_l1_line_ctl #(.DATA_W(W)) i_msi_l1_line_ctl (
    .clk(clk), .rst(rst),
    .cpu_valid(cpu_valid), .cpu_op(cpu_op), .cpu_wdata(cpu_wdata),
    .fwd_valid(fwd_valid), .fwd_op(fwd_op),
    .fill_valid(fill_valid), .fill_op(fill_op), .fill_data(fill_data),
    .cpu_pop(cpu_pop), .fwd_pop(fwd_pop), .fill_pop(fill_pop), .cpu_stall(cpu_stall),
    .load_done(load_done), .load_data(load_data), .store_done(store_done),
    .req_valid(req_valid), .req_type(req_type), .req_data(req_data),
    .resp_valid(resp_valid), .resp_type(resp_type), .resp_data(resp_data),
    .line_state(line_state), .line_perm(line_perm), .proto_err(proto_err)
  );

  int n_chk = 0, n_err = 0;
  int m_st;
  logic [W-1:0] m_line, m_tbuf, m_pend;
  bit m_err;
  bit e_cpop, e_fpop, e_rpop, e_stall, e_ld, e_sd, e_qv, e_pv, e_pt;
  int e_qt;
  logic [W-1:0] e_rd, e_qd, e_pd;

  function automatic int exp_perm(int s);
    if (s == NP || s == I || s == SI || s == MI) return 0;
    if (s == S) return 1;
    if (s == M) return 2;
    return 3;
  endfunction

  task automatic chk(string tag, string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic clear_exp();
    {e_cpop, e_fpop, e_rpop, e_stall, e_ld, e_sd, e_qv, e_pv, e_pt} = '0;
    e_qt = 0; e_rd = '0; e_qd = '0; e_pd = '0;
  endtask

  task automatic send(logic [W-1:0] d);
    e_pv = 1; e_pt = 0; e_pd = d;
  endtask

  // reference model written from the requirements
  task automatic model(bit cv, int cop, logic [W-1:0] wd, bit fv, int fop,
                       bit rv, int rop, logic [W-1:0] fd);
    bit bad = 0;
    clear_exp();
    if (rv) begin
      e_rpop = 1;
      case (m_st)
        IS: if (rop == 0 || rop == 2) begin
              m_line = fd; e_ld = 1; e_rd = fd; m_st = (rop == 0) ? S : I;
            end else bad = 1;
        ISI: if (rop == 0) begin m_line = fd; e_ld = 1; e_rd = fd; m_st = I; end
             else bad = 1;
        IM: if (rop == 3) bad = 1;
            else begin
              m_line = m_pend; e_sd = 1;
              m_st = (rop == 0) ? M : (rop == 1) ? S : I;
              if (rop != 0) send(m_pend);
            end
        IMI, IMS, IMSI: if (rop == 0) begin
              m_line = m_pend; e_sd = 1; send(m_pend);
              m_st = (m_st == IMS) ? S : I;
            end else bad = 1;
        SI, MI: if (rop == 3) m_st = I; else bad = 1;
        default: bad = 1;
      endcase
    end else if (fv) begin
      e_fpop = 1;
      case (m_st)
        S:   if (fop == 1) begin e_pv = 1; e_pt = 1; m_st = I; end else bad = 1;
        M:   if (fop == 0 || fop == 2) begin send(m_line); m_st = (fop == 0) ? I : S; end
             else bad = 1;
        IS:  if (fop == 1) begin e_pv = 1; e_pt = 1; m_st = ISI; end else bad = 1;
        IM:  if (fop == 0) m_st = IMI;
             else if (fop == 2) m_st = IMS;
             else if (fop == 1) begin e_pv = 1; e_pt = 1; end
             else bad = 1;
        IMS: if (fop == 1) m_st = IMSI; else bad = 1;
        SI:  if (fop == 1) begin e_pv = 1; e_pt = 1; end else bad = 1;
        MI:  if (fop == 0 || fop == 2) begin send(m_tbuf); if (fop == 2) m_st = SI; end
             else bad = 1;
        default: bad = 1;
      endcase
    end else if (cv && m_st < IS) begin
      e_cpop = 1;
      if (cop > 4) bad = 1;
      else if (m_st == NP || m_st == I) begin
        if (cop <= 2) begin e_qv = 1; e_qt = cop; end
        if (cop == 2) m_pend = wd;
        m_st = (cop <= 1) ? IS : (cop == 2) ? IM : NP;
      end else if (cop <= 1) begin
        e_ld = 1; e_rd = m_line;
      end else if (m_st == S) begin
        e_qv = 1;
        if (cop == 2) begin e_qt = 3; m_pend = wd; m_st = IM; end
        else begin e_qt = 4; e_qd = m_line; m_tbuf = m_line; m_st = SI; end
      end else begin
        if (cop == 2) begin m_line = wd; e_sd = 1; end
        else begin e_qv = 1; e_qt = 5; e_qd = m_line; m_tbuf = m_line; m_st = MI; end
      end
    end
    e_stall = cv && !e_cpop;
    if (bad) m_err = 1;
  endtask

  task automatic compare(string tag);
    chk(tag, "state", line_state, m_st);
    chk("R12", "perm", line_perm, exp_perm(m_st));
    chk(tag, "proto_err", proto_err, m_err);
    chk(tag, "pops", {cpu_pop, fwd_pop, fill_pop}, {e_cpop, e_fpop, e_rpop});
    chk(tag, "stall", cpu_stall, e_stall);
    chk(tag, "load_done", load_done, e_ld);
    if (e_ld) chk(tag, "load_data", load_data, e_rd);
    chk(tag, "store_done", store_done, e_sd);
    chk(tag, "req_valid", req_valid, e_qv);
    if (e_qv) begin
      chk(tag, "req_type", req_type, e_qt);
      if (e_qt >= 4) chk(tag, "req_data", req_data, e_qd);
    end
    chk(tag, "resp_valid", resp_valid, e_pv);
    if (e_pv) begin
      chk(tag, "resp_type", resp_type, e_pt);
      if (!e_pt) chk(tag, "resp_data", resp_data, e_pd);
    end
  endtask

  // drive at a falling edge, result appears after the next rising edge (R14)
  task automatic step(string tag, bit cv, int cop, logic [W-1:0] wd, bit fv, int fop,
                      bit rv, int rop, logic [W-1:0] fd);
    cpu_valid = cv; cpu_op = 3'(cop); cpu_wdata = wd;
    fwd_valid = fv; fwd_op = 2'(fop);
    fill_valid = rv; fill_op = 2'(rop); fill_data = fd;
    model(cv, cop, wd, fv, fop, rv, rop, fd);
    @(posedge clk); @(negedge clk);
    cpu_valid = 0; fwd_valid = 0; fill_valid = 0;
    compare(tag);
  endtask

  task automatic do_reset();
    rst = 1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 0;
    m_st = NP; m_err = 0; m_line = '0; m_tbuf = '0; m_pend = '0;
    clear_exp();
    compare("R1");
  endtask

  task automatic cpu(string t, int op, logic [W-1:0] d = '0);
    step(t, 1, op, d, 0, 0, 0, 0, '0);
  endtask
  task automatic fwd(string t, int op);
    step(t, 0, 0, '0, 1, op, 0, 0, '0);
  endtask
  task automatic fill(string t, int op, logic [W-1:0] d = '0);
    step(t, 0, 0, '0, 0, 0, 1, op, d);
  endtask

  task automatic run_all();
    do_reset();
    // R4 / R3 / R7: load miss, stalled load, fill to S
    cpu("R4", 0);
    cpu("R3", 0);
    cpu("R3", 2, 16'h1111);
    fill("R7", 0, 16'hA5A5);
    cpu("R5", 1);                  // ifetch hit returns A5A5
    cpu("R5", 2, 16'h3C3C);        // UPGRADE, IM
    fwd("R8", 1);                  // ack, stays IM
    fwd("R8", 2);                  // IMS
    fwd("R8", 1);                  // IMSI
    fill("R10", 0, 16'h0F0F);      // I, store data 3C3C sent
    // R9: exclusive fill, then modified behaviour
    cpu("R4", 2, 16'h5555);
    fill("R9", 0, 16'h0000);       // M, line 5555
    cpu("R6", 2, 16'h6666);        // store hit
    cpu("R6", 0);                  // load hit 6666
    cpu("R6", 3);                  // PUTX 6666, MI
    fwd("R11", 0);                 // data from buffer, stay MI
    fwd("R11", 2);                 // data from buffer, SI
    fwd("R11", 1);                 // ack in SI
    fill("R11", 3);                // put-ack, I
    // R7 race in IS, then ISI fill
    cpu("R4", 1);
    fwd("R7", 1);
    fill("R7", 0, 16'h7777);
    // R9 data-then-shared / data-then-idle
    cpu("R4", 2, 16'h8888);
    fill("R9", 1, 16'h1234);
    cpu("R5", 3);                  // PUTS 8888, SI
    fill("R11", 3);
    cpu("R4", 2, 16'h9999);
    fwd("R8", 0);                  // IMI, no response
    fill("R10", 0, 16'h4321);
    cpu("R4", 2, 16'hAAAA);
    fill("R9", 2, 16'h0);          // I, send AAAA
    // R2 collisions
    cpu("R4", 0);
    fill("R7", 0, 16'hBEEF);       // S
    step("R2", 1, 2, 16'hCAFE, 1, 1, 0, 0, '0);   // fwd wins, store stalls
    cpu("R4", 2, 16'hD00D);
    step("R2", 1, 0, '0, 1, 2, 1, 0, 16'h1);      // fill wins over fwd and cpu
    cpu("R6", 3);                  // replace in M, PUTX D00D
    cpu("R4", 4);                  // stalls in MI
    fill("R11", 3);
    cpu("R4", 3);                  // replace in I -> NP
    // R13: illegal fill in NP, sticky, cleared by reset
    fill("R13", 0, 16'h1);
    cpu("R13", 0);
    fwd("R13", 3);
    do_reset();
    cpu("R13", 6);
    // seeded random traffic
    void'($urandom(32'd2024));
    for (int k = 0; k < 3000; k++) begin
      bit cv, fv, rv;
      int cop, fop, rop;
      if (k % 64 == 0) do_reset();
      cv = ($urandom % 2) == 0;
      fv = ($urandom % 4) == 0;
      rv = (m_st >= IS) ? (($urandom % 5) < 2) : (($urandom % 20) == 0);
      cop = (($urandom % 16) == 0) ? 5 : int'($urandom % 5);
      fop = (($urandom % 16) == 0) ? 3 : int'($urandom % 3);
      rop = int'($urandom % 4);
      step("R2", cv, cop, 16'($urandom), fv, fop, rv, rop, 16'($urandom));
    end
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL R14 watchdog: actual hung expected finished");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule